// File: doc/BRIEF.md
# Counter-Paced Write/Execute Phase Sequencer

Each computing node in a loosely clocked distributed system runs this sequencer to keep its write (broadcast) activity and its execute activity in an alternating rhythm with its peers. No shared clock is needed. The node only has its own periodic tick, a single down-counter and a flag that reports a peer's write. While the counter is above zero, a tick only decrements it. When the counter is at zero, the current phase completes: in the write-wait phase the node broadcasts, and in the execute-wait phase it starts a computation and freezes the inputs of that computation.

The reload value taken at each phase change depends on how the node got there. A write can be self-timed (counter expired, no peer write seen) or peer-triggered (a peer write was seen). Each case has its own reload for the execute wait that follows and its own reload for the next write wait. Four reload constants are captured while reset is held. With constants A (self write), B (peer write), C (execute after a self write) and D (execute after a peer write), an undisturbed node writes every A+C+2 ticks. If a peer or link fails silently, the node keeps running on its own counter. It then executes on whatever inputs it holds.

Top module: `bcast_exec_seq`

## Requirements
- R1: On a tick with the counter above zero, no strobe fires, the phase is unchanged and the counter drops by one.
- R2: In the write-wait phase, on a tick with the counter at zero and no peer flag, the write strobe fires and the counter reloads with A. The first write after reset therefore comes on tick A+1, and the execute start comes A+1 ticks after the write.
- R3: In the write-wait phase, a tick with the peer flag high fires the write strobe immediately, whatever the count is, and reloads the counter with B.
- R4: In the execute-wait phase, on a tick with the counter at zero, the execute strobe fires and the counter reloads with D if the preceding write was peer-triggered and with C otherwise. The next self-timed write then comes that value plus one ticks later.
- R5: The freeze pulse fires in exactly the cycles in which the execute strobe fires.
- R6: While reset is held and right after it, the phase is write-wait, all strobes are low and the counter holds A.
- R7: The reload inputs are captured only while reset is high. Changing them afterwards has no effect on timing.
- R8: The peer flag has no effect in the execute-wait phase, and it has no effect on cycles without a tick.
- R9: Each strobe is high for one clock cycle, in the cycle after the tick that caused it. The write and execute strobes are never high together.
- R10: The phase output is 0 in write-wait and 1 in execute-wait. It changes to 1 with each write strobe and to 0 with each execute strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reload inputs are captured while high |
| tick_i | input | 1 | Local time-base tick, one clock wide |
| peer_wr_i | input | 1 | A peer's write was observed (qualified by tick) |
| rld_wr_self_i | input | 8 | Reload A after a self-timed write; also the count after reset |
| rld_wr_peer_i | input | 8 | Reload B after a peer-triggered write |
| rld_ex_self_i | input | 8 | Reload C after execute on the self-timed branch |
| rld_ex_peer_i | input | 8 | Reload D after execute on the peer branch |
| wr_strobe_o | output | 1 | Broadcast-outputs strobe |
| exec_start_o | output | 1 | Start-execution strobe |
| freeze_o | output | 1 | Freeze-inputs pulse |
| phase_o | output | 1 | 0 = write-wait, 1 = execute-wait |

## Verification
A wrong counter value shifts the next strobe by the size of the error, so the fault shows up within one write/execute period of A+C+2 ticks. The sweeps therefore compare the tick number of every strobe against closed-form positions. A branch flag that is stuck or wrong selects the other execute-to-write reload. This is visible on the first write that follows a peer-triggered write, provided D differs from C. A phase register that is stuck would let a peer flag fire a write during execute-wait, and it would break the strict alternation of the strobes on the very next tick.

// File: rtl/seq_pkg.sv
package seq_pkg;
    parameter int CNT_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {PH_WRITE = 1'b0, PH_EXEC = 1'b1} phase_e;
    typedef enum logic {BR_SELF = 1'b0, BR_PEER = 1'b1} branch_e;

    typedef struct packed {
        cnt_t wr_self;
        cnt_t wr_peer;
        cnt_t ex_self;
        cnt_t ex_peer;
    } reload_t;

    function automatic cnt_t exec_reload(reload_t c, branch_e b);
        return (b == BR_PEER) ? c.ex_peer : c.ex_self;
    endfunction

    function automatic cnt_t write_reload(reload_t c, logic peer);
        return peer ? c.wr_peer : c.wr_self;
    endfunction
endpackage

// File: rtl/seq_reload_latch.sv
module seq_reload_latch
    import seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  reload_t cfg_i,
    output reload_t cfg_o
);
    reload_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= cfg_i;
    end

    assign cfg_o = cfg_q;

    // R7: constants hold while out of reset
    a_r7_cfg_stable: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(cfg_q));
endmodule

// File: rtl/seq_downcounter.sv
module seq_downcounter
    import seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic load_i,
    input  cnt_t load_val_i,
    input  cnt_t rst_val_i,
    output logic zero_o
);
    cnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                        cnt_q <= rst_val_i;
        else if (load_i)                cnt_q <= load_val_i;
        else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R1: a plain tick on a nonzero count steps down by one
    a_r1_decrement: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R1: no tick, no load -> count holds
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/seq_phase_ctrl.sv
module seq_phase_ctrl
    import seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick_i,
    input  logic    peer_i,
    input  logic    zero_i,
    input  reload_t cfg_i,
    output logic    load_o,
    output cnt_t    load_val_o,
    output logic    wr_o,
    output logic    ex_o,
    output logic    frz_o,
    output phase_e  phase_o
);
    phase_e  phase_q;
    branch_e branch_q;
    logic    wr_q, ex_q, frz_q;
    logic    do_wr, do_ex;

    always_comb begin
        do_wr = tick_i && (phase_q == PH_WRITE) && (peer_i || zero_i);
        do_ex = tick_i && (phase_q == PH_EXEC) && zero_i;
        load_o = do_wr || do_ex;
        load_val_o = do_wr ? write_reload(cfg_i, peer_i)
                           : exec_reload(cfg_i, branch_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_WRITE;
            branch_q <= BR_SELF;
            wr_q     <= 1'b0;
            ex_q     <= 1'b0;
            frz_q    <= 1'b0;
        end else begin
            wr_q  <= do_wr;
            ex_q  <= do_ex;
            frz_q <= do_ex;
            if (do_wr) begin
                phase_q  <= PH_EXEC;
                branch_q <= peer_i ? BR_PEER : BR_SELF;
            end else if (do_ex) begin
                phase_q <= PH_WRITE;
            end
        end
    end

    assign wr_o    = wr_q;
    assign ex_o    = ex_q;
    assign frz_o   = frz_q;
    assign phase_o = phase_q;

    // R9: strobes exclusive and one cycle wide
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(wr_q && ex_q));
    a_r9_wr_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_q |=> !wr_q);
    a_r9_ex_pulse: assert property (@(posedge clk) disable iff (rst)
        ex_q |=> !ex_q);
    // R3: peer flag on a tick in write-wait forces a write
    a_r3_peer_write: assert property (@(posedge clk) disable iff (rst)
        (tick_i && peer_i && phase_q == PH_WRITE) |=> wr_q);
    // R8: no strobe without a tick
    a_r8_no_tick_no_wr: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> !wr_q && !ex_q);
    // R10: phase tracks the strobes
    a_r10_wr_phase: assert property (@(posedge clk) disable iff (rst)
        wr_q |-> phase_q == PH_EXEC);
    a_r10_ex_phase: assert property (@(posedge clk) disable iff (rst)
        ex_q |-> phase_q == PH_WRITE);
endmodule

// File: rtl/bcast_exec_seq.sv
module bcast_exec_seq
    import seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             peer_wr_i,
    input  logic [CNT_W-1:0] rld_wr_self_i,
    input  logic [CNT_W-1:0] rld_wr_peer_i,
    input  logic [CNT_W-1:0] rld_ex_self_i,
    input  logic [CNT_W-1:0] rld_ex_peer_i,
    output logic             wr_strobe_o,
    output logic             exec_start_o,
    output logic             freeze_o,
    output logic             phase_o
);
    reload_t cfg_in, cfg;
    logic    zero, load;
    cnt_t    load_val;
    phase_e  phase;

    assign cfg_in = '{wr_self: rld_wr_self_i, wr_peer: rld_wr_peer_i,
                      ex_self: rld_ex_self_i, ex_peer: rld_ex_peer_i};

    seq_reload_latch u_latch (
        .clk(clk), .rst(rst), .cfg_i(cfg_in), .cfg_o(cfg)
    );

    seq_downcounter u_cnt (
        .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load),
        .load_val_i(load_val), .rst_val_i(rld_wr_self_i), .zero_o(zero)
    );

    seq_phase_ctrl u_ctrl (
        .clk(clk), .rst(rst), .tick_i(tick_i), .peer_i(peer_wr_i),
        .zero_i(zero), .cfg_i(cfg), .load_o(load), .load_val_o(load_val),
        .wr_o(wr_strobe_o), .ex_o(exec_start_o), .frz_o(freeze_o),
        .phase_o(phase)
    );

    assign phase_o = phase;
endmodule

// File: tb/sim_bcast_exec_seq.sv
module sim_bcast_exec_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       peer = 1'b0;
    logic [7:0] ra = 8'd0, rb = 8'd0, rc = 8'd0, rd = 8'd0;
    logic       wr, ex, frz, ph;
    int         checks = 0;
    int         errors = 0;
    logic       s_wr, s_ex, s_frz, s_ph;

    always #2 clk = ~clk;

    bcast_exec_seq u0 (
        .clk(clk), .rst(rst), .tick_i(tick), .peer_wr_i(peer),
        .rld_wr_self_i(ra), .rld_wr_peer_i(rb),
        .rld_ex_self_i(rc), .rld_ex_peer_i(rd),
        .wr_strobe_o(wr), .exec_start_o(ex), .freeze_o(frz), .phase_o(ph)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input int a, input int b, input int c, input int d);
        @(negedge clk);
        rst = 1'b1; tick = 1'b0; peer = 1'b0;
        ra = 8'(a); rb = 8'(b); rc = 8'(c); rd = 8'(d);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R7: scramble the reload inputs after reset
        ra = 8'hFF; rb = 8'hFF; rc = 8'hFF; rd = 8'hFF;
    endtask

    // one tick; outputs sampled one clock later, then width checked
    task automatic do_tick(input logic p);
        @(negedge clk);
        tick = 1'b1; peer = p;
        @(negedge clk);
        tick = 1'b0; peer = 1'b0;
        s_wr = wr; s_ex = ex; s_frz = frz; s_ph = ph;
        chk("R5 freeze", int'(s_frz), int'(s_ex));
        chk("R9 exclusive", int'(s_wr && s_ex), 0);
        @(negedge clk);
        chk("R9 width", int'(wr || ex || frz), 0);
    endtask

    initial begin
        // R6: reset state
        do_reset(3, 2, 2, 2);
        chk("R6 phase", int'(ph), 0);
        chk("R6 strobes", int'(wr || ex || frz), 0);

        // R1 R2 R4 R7 R10: self-timed sweep
        for (int a = 0; a < 4; a++) begin
            for (int c = 0; c < 4; c++) begin
                int p;
                p = a + c + 2;
                do_reset(a, 9, c, 9);
                for (int t = 1; t <= 3 * p; t++) begin
                    int ew, ee, eph, r;
                    do_tick(1'b0);
                    ew = (t >= a + 1 && (t - a - 1) % p == 0) ? 1 : 0;
                    ee = (t >= 2 * a + 2 && (t - 2 * a - 2) % p == 0) ? 1 : 0;
                    if (t < a + 1) eph = 0;
                    else begin
                        r = (t - a - 1) % p;
                        eph = (r <= a) ? 1 : 0;
                    end
                    chk("R2 R1 write", int'(s_wr), ew);
                    chk("R4 R7 exec", int'(s_ex), ee);
                    chk("R10 phase", int'(s_ph), eph);
                end
            end
        end

        // R3 R4 R8: peer branch, A=3 B=1 C=2 D=4
        do_reset(3, 1, 2, 4);
        for (int t = 1; t <= 15; t++) begin
            int ew, ee;
            if (t == 13) begin
                // R8: peer flag without tick
                @(negedge clk);
                peer = 1'b1;
                @(negedge clk);
                peer = 1'b0;
                @(negedge clk);
                chk("R8 no tick", int'(wr), 0);
            end
            do_tick((t == 1 || t == 2) ? 1'b1 : 1'b0);
            ew = (t == 1 || t == 8 || t == 15) ? 1 : 0;
            ee = (t == 3 || t == 12) ? 1 : 0;
            if (t == 1) chk("R3 peer write", int'(s_wr), ew);
            else if (t == 2) chk("R8 exec-wait peer", int'(s_wr), ew);
            else chk("R4 branch write", int'(s_wr), ew);
            chk("R4 branch exec", int'(s_ex), ee);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule